// File: doc/BRIEF.md
# Memory access wait-state inserter

This block sits beside the bus controller of a Z80-style processor and decides, at the start of every memory cycle, whether that cycle must be stretched by a single clock. It holds an 8-bit penalty register, written and read through an I/O port. Three of its bits cover the flash region and three cover the RAM region. Within each group, one bit covers opcode fetches, one covers ordinary reads and one covers writes. The two remaining bits do nothing but still store data and read back.

Two further enable bits gate the penalties. One allows the flash group and the other allows the RAM group. They are taken from one of two candidate enable sources, and the current CPU speed mode selects which one. Address decoding into a region is done elsewhere and arrives as an input. The block answers with a one-clock wait request, raised in the clock after the cycle-start strobe.

Top module: `memwait_gen`

## Requirements
- R1: After reset the penalty register reads back the parameter `CFG_RESET` (default 8'h44) and `wait_req` is low.
- R2: A write through `cfg_wr_en`/`cfg_wr_data` stores all 8 bits, bits 3 and 7 included, and `cfg_rd_data` shows the stored value from the next clock. The value holds while no write occurs.
- R3: For region 2'b01 (flash), when the flash group is enabled, a wait is raised in three cases: bit 0 with kind 2'b00 (opcode fetch), bit 1 with kind 2'b01 (read), and bit 2 with kind 2'b10 (write, whether or not the write has any effect).
- R4: For region 2'b10 (RAM), when the RAM group is enabled, a wait is raised in three cases: bit 4 with an opcode fetch, bit 5 with a read, and bit 6 with a write.
- R5: The flash group applies only when bit 0 of the selected enable pair is 1. The RAM group applies only when bit 1 of that pair is 1.
- R6: `speed_sel`=0 selects `slow_en` as the enable pair, and `speed_sel`=1 selects `fast_en`.
- R7: A qualifying cycle whose `cyc_start` is sampled at clock edge N gives `wait_req` high for exactly the one clock after edge N. `wait_req` is never high unless `cyc_start` was high at the previous edge.
- R8: Kind 2'b11 (I/O cycle) never produces a wait, and neither does region 2'b00 or 2'b11 (neither flash nor RAM).
- R9: Suppose a penalty register write is sampled at the same edge as `cyc_start`. That cycle is judged with the old value, and the new value applies from the next cycle.
- R10: Back-to-back opcode fetches, as in a prefixed instruction, each earn their own one-clock penalty, so `wait_req` stays high for two clocks.
- R11: Bits 3 and 7 have no effect on timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Penalty register write strobe |
| cfg_wr_data | input | 8 | Penalty register write data |
| cfg_rd_data | output | 8 | Penalty register read-back value |
| speed_sel | input | 1 | CPU speed mode: 0 slow, 1 fast |
| slow_en | input | 2 | Enable pair for slow mode (bit 0 flash, bit 1 RAM) |
| fast_en | input | 2 | Enable pair for fast mode (bit 0 flash, bit 1 RAM) |
| cyc_start | input | 1 | One-clock strobe marking the start of a bus cycle |
| cyc_kind | input | 2 | 00 fetch, 01 read, 10 write, 11 I/O |
| region | input | 2 | 01 flash, 10 RAM, 00/11 neither |
| wait_req | output | 1 | One-clock wait request to the bus controller |

## Verification
A penalty register write and the start of a memory cycle can land on the same clock edge. The bench raises both strobes in one cycle. In one case the new value would grant a wait that the old value denies, and in another the reverse holds. It then expects the outcome given by the old value for that cycle and by the new value for the next cycle.

// File: rtl/memwait_gen.sv
module memwait_gen #(
  parameter logic [7:0] CFG_RESET = 8'h44
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr_en,
  input  logic [7:0] cfg_wr_data,
  output logic [7:0] cfg_rd_data,
  input  logic       speed_sel,
  input  logic [1:0] slow_en,
  input  logic [1:0] fast_en,
  input  logic       cyc_start,
  input  logic [1:0] cyc_kind,
  input  logic [1:0] region,
  output logic       wait_req
);

  logic [7:0] cfg_q;
  logic [1:0] en_sel;
  logic [2:0] grp_bits;
  logic       grp_gate;
  logic       kind_hit;
  logic       wait_q;

  assign en_sel = speed_sel ? fast_en : slow_en;

  always_comb begin
    grp_bits = 3'b000;
    grp_gate = 1'b0;
    case (region)
      2'b01: begin grp_bits = cfg_q[2:0]; grp_gate = en_sel[0]; end
      2'b10: begin grp_bits = cfg_q[6:4]; grp_gate = en_sel[1]; end
      default: ;
    endcase
  end

  always_comb begin
    case (cyc_kind)
      2'b00:   kind_hit = grp_bits[0];
      2'b01:   kind_hit = grp_bits[1];
      2'b10:   kind_hit = grp_bits[2];
      default: kind_hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q  <= CFG_RESET;
      wait_q <= 1'b0;
    end else begin
      if (cfg_wr_en) cfg_q <= cfg_wr_data;
      wait_q <= cyc_start & grp_gate & kind_hit;
    end
  end

  assign cfg_rd_data = cfg_q;
  assign wait_req    = wait_q;

endmodule

module memwait_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_wr_en,
  input logic [7:0] cfg_wr_data,
  input logic [7:0] cfg_rd_data,
  input logic       speed_sel,
  input logic [1:0] slow_en,
  input logic [1:0] fast_en,
  input logic       cyc_start,
  input logic [1:0] cyc_kind,
  input logic [1:0] region,
  input logic       wait_req
);

  p_wait_after_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_start |=> !wait_req);

  p_io_nowait_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && cyc_kind == 2'b11) |=> !wait_req);

  p_noregion_nowait_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && (region == 2'b00 || region == 2'b11)) |=> !wait_req);

  p_cfg_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en |=> cfg_rd_data == $past(cfg_wr_data));

  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr_en |=> $stable(cfg_rd_data));

  p_flash_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && region == 2'b01 && !(speed_sel ? fast_en[0] : slow_en[0])) |=> !wait_req);

  p_ram_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && region == 2'b10 && !(speed_sel ? fast_en[1] : slow_en[1])) |=> !wait_req);

endmodule

bind memwait_gen memwait_gen_chk u_chk (.*);

// File: tb/memwait_gen_tb.sv
module memwait_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr_en = 1'b0;
  logic [7:0] cfg_wr_data = 8'h00;
  logic [7:0] cfg_rd_data;
  logic       speed_sel = 1'b0;
  logic [1:0] slow_en = 2'b00;
  logic [1:0] fast_en = 2'b00;
  logic       cyc_start = 1'b0;
  logic [1:0] cyc_kind = 2'b00;
  logic [1:0] region = 2'b00;
  logic       wait_req;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  memwait_gen u_dut (.*);

  // {cfg[8], speed_sel, slow_en[2], fast_en[2], kind[2], region[2], expected}
  localparam int NV = 18;
  localparam logic [17:0] VEC [NV] = '{
    {8'h01, 1'b0, 2'b01, 2'b00, 2'b00, 2'b01, 1'b1},  // R3 fetch flash
    {8'h01, 1'b0, 2'b01, 2'b00, 2'b01, 2'b01, 1'b0},  // R3 read, bit1 clear
    {8'h02, 1'b0, 2'b01, 2'b00, 2'b01, 2'b01, 1'b1},  // R3 read flash
    {8'h04, 1'b0, 2'b01, 2'b00, 2'b10, 2'b01, 1'b1},  // R3 write flash
    {8'h04, 1'b0, 2'b10, 2'b00, 2'b10, 2'b01, 1'b0},  // R5 flash gated
    {8'h10, 1'b0, 2'b10, 2'b00, 2'b00, 2'b10, 1'b1},  // R4 fetch ram
    {8'h20, 1'b0, 2'b10, 2'b00, 2'b01, 2'b10, 1'b1},  // R4 read ram
    {8'h40, 1'b0, 2'b10, 2'b00, 2'b10, 2'b10, 1'b1},  // R4 write ram
    {8'h40, 1'b0, 2'b01, 2'b00, 2'b10, 2'b10, 1'b0},  // R5 ram gated
    {8'h77, 1'b1, 2'b11, 2'b00, 2'b00, 2'b10, 1'b0},  // R6 fast pair off
    {8'h77, 1'b1, 2'b00, 2'b11, 2'b00, 2'b10, 1'b1},  // R6 fast pair on
    {8'h77, 1'b0, 2'b00, 2'b11, 2'b00, 2'b01, 1'b0},  // R6 slow pair off
    {8'h77, 1'b1, 2'b00, 2'b11, 2'b11, 2'b01, 1'b0},  // R8 io cycle
    {8'h77, 1'b1, 2'b00, 2'b11, 2'b00, 2'b00, 1'b0},  // R8 no region
    {8'h77, 1'b1, 2'b00, 2'b11, 2'b01, 2'b11, 1'b0},  // R8 region 11
    {8'h88, 1'b0, 2'b11, 2'b00, 2'b01, 2'b01, 1'b0},  // R11 bits 3/7 only
    {8'h07, 1'b0, 2'b11, 2'b00, 2'b10, 2'b10, 1'b0},  // R4 flash bits on ram
    {8'h70, 1'b0, 2'b11, 2'b00, 2'b00, 2'b01, 1'b0}   // R3 ram bits on flash
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [7:0] v);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_data = v;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic run_cycle(input string tag, input logic [1:0] k, input logic [1:0] r, input logic exp);
    @(negedge clk);
    cyc_kind = k; region = r; cyc_start = 1'b1;
    @(negedge clk);
    check(tag, {7'd0, wait_req}, {7'd0, exp});
    cyc_start = 1'b0;
    @(negedge clk);
    check({tag, " R7 drop"}, {7'd0, wait_req}, 8'h00);
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset cfg", cfg_rd_data, 8'h44);
    check("R1 reset wait", {7'd0, wait_req}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      write_cfg(VEC[i][17:10]);
      check("R2 readback", cfg_rd_data, VEC[i][17:10]);
      speed_sel = VEC[i][9];
      slow_en = VEC[i][8:7];
      fast_en = VEC[i][6:5];
      run_cycle($sformatf("vec%0d", i), VEC[i][4:3], VEC[i][2:1], VEC[i][0]);
    end

    write_cfg(8'hFF);
    check("R2 all bits", cfg_rd_data, 8'hFF);
    repeat (3) @(negedge clk);
    check("R2 hold", cfg_rd_data, 8'hFF);
    write_cfg(8'h88);
    check("R11 bits 3 7 readback", cfg_rd_data, 8'h88);

    speed_sel = 1'b0; slow_en = 2'b11;
    write_cfg(8'h00);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_data = 8'h01;
    cyc_kind = 2'b00; region = 2'b01; cyc_start = 1'b1;
    @(negedge clk);
    check("R9 old value used", {7'd0, wait_req}, 8'h00);
    cfg_wr_en = 1'b0; cyc_start = 1'b0;
    run_cycle("R9 new value used", 2'b00, 2'b01, 1'b1);

    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_data = 8'h00;
    cyc_kind = 2'b00; region = 2'b01; cyc_start = 1'b1;
    @(negedge clk);
    check("R9 old value grants", {7'd0, wait_req}, 8'h01);
    cfg_wr_en = 1'b0; cyc_start = 1'b0;
    run_cycle("R9 new value denies", 2'b00, 2'b01, 1'b0);

    write_cfg(8'h10);
    @(negedge clk);
    cyc_kind = 2'b00; region = 2'b10; cyc_start = 1'b1;
    @(negedge clk);
    check("R10 first fetch", {7'd0, wait_req}, 8'h01);
    @(negedge clk);
    check("R10 second fetch", {7'd0, wait_req}, 8'h01);
    cyc_start = 1'b0;
    @(negedge clk);
    check("R10 R7 end", {7'd0, wait_req}, 8'h00);

    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset again", cfg_rd_data, 8'h44);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule